// File: doc/BRIEF.md
# Watchdog with Prewarning Phase

This block is a watchdog timer that counts up once per clock from a value that software chooses. Software keeps it alive by pulsing a service strobe, which reloads the counter. If the counter wraps past its all-ones value, the watchdog does not demand a reset straight away. It first enters a prewarning phase. In that phase it pulses an interrupt and counts a fixed, shorter window. If that window also runs out, it raises a reset request.

An internal "already expired" flag records that the watchdog has run out at least once. The flag is kept through a user reset and is cleared only by a power reset, or by software while the watchdog is in its prewarning phase. Whenever the flag is still set at a later expiry, the block enters a locked state. The locked reset request survives user resets and is released only by a power reset. Software can therefore let the watchdog run out once on purpose, for example in a self test. It must then clear the flag during the prewarning window, or every later expiry will lock the system in reset.

The reset input is synchronous and active low. A second input, sampled while reset is held, selects between a user reset and a power reset.

Top module: `wdog_prewarn`

## Requirements
- R1: A power reset (`rst_n` low with `rst_is_power` = 1 at a clock edge) clears the expired flag and the lock. After it, `prewarn_irq`, `rst_req` and `was_expired` read 0, and the counter holds `reload_val`.
- R2: In the normal phase the counter rises by one on each clock. A `service` pulse reloads it with `reload_val`. The counter expires on the edge where it would pass the all-ones value, which comes 2^CNT_W − R edges after it was loaded with R.
- R3: An expiry in the normal phase while the flag is clear enters the prewarning phase. `prewarn_irq` is high for exactly one cycle, the flag is set, and the counter restarts so that the prewarning window lasts PREWARN_CYCLES edges.
- R4: `service` has no effect during the prewarning phase. The window still ends PREWARN_CYCLES edges after it began.
- R5: If the window ends while the flag has been cleared, `rst_req` rises and stays high. Any reset (user or power) drops it.
- R6: If the window ends while the flag is still set, the block locks and `rst_req` rises.
- R7: A `clr_flag` pulse clears the flag only during the prewarning phase. In the normal phase or while a reset request is pending, it leaves `was_expired` unchanged.
- R8: A user reset (`rst_is_power` = 0) keeps the flag. A later expiry in the normal phase with the flag set raises `rst_req` with the lock, and no prewarning interrupt is issued.
- R9: While locked, `rst_req` stays at 1 through user resets and the counter stops, so no further interrupts occur. Only a power reset releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rst_is_power | input | 1 | Reset kind while `rst_n` is low: 1 = power reset, 0 = user reset |
| service | input | 1 | Service strobe; reloads the counter in the normal phase |
| clr_flag | input | 1 | Write-one strobe that clears the expired flag (prewarning phase only) |
| reload_val | input | CNT_W | Counter start value after reset or service |
| prewarn_irq | output | 1 | One-cycle interrupt on entry to the prewarning phase |
| rst_req | output | 1 | Reset request (held or locked) |
| was_expired | output | 1 | Current state of the expired flag |

## Verification
On every cycle the embedded properties check several local rules. The interrupt is a single-cycle pulse and coincides with the flag being set. Service strobes cannot shorten the prewarning window. A reset request stays high until a reset arrives, and the lock stays set until a power reset. The flag can fall only through a prewarning-phase clear or a reset. What the bench scenarios alone can show is the whole sequence of events across resets. This covers the exact expiry cycles computed from the reload value, a cleared flag giving a releasable request, and an uncleared flag giving a lock. It also covers a user reset during prewarning leading straight to a lock at the next expiry, with no interrupt.

// File: rtl/wdog_prewarn.sv
module wdog_prewarn #(
  parameter int CNT_W          = 16,
  parameter int PREWARN_CYCLES = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_is_power,
  input  logic             service,
  input  logic             clr_flag,
  input  logic [CNT_W-1:0] reload_val,
  output logic             prewarn_irq,
  output logic             rst_req,
  output logic             was_expired
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] PW_START = CNT_MAX - CNT_W'(PREWARN_CYCLES - 1);

  typedef enum logic [1:0] {M_RUN, M_WARN, M_HOLD} mode_t;

  mode_t            mode;
  logic [CNT_W-1:0] cnt;
  logic             flag, lock, irq;

  wire ovf = (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= reload_val;
      mode <= M_RUN;
      irq  <= 1'b0;
      if (rst_is_power) begin
        flag <= 1'b0;
        lock <= 1'b0;
      end
    end else begin
      irq <= 1'b0;
      if (!lock) begin
        case (mode)
          M_RUN: begin
            if (service) begin
              cnt <= reload_val;
            end else if (ovf) begin
              if (flag) begin
                lock <= 1'b1;
                mode <= M_HOLD;
              end else begin
                flag <= 1'b1;
                irq  <= 1'b1;
                mode <= M_WARN;
                cnt  <= PW_START;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          M_WARN: begin
            if (clr_flag) flag <= 1'b0;
            if (ovf) begin
              mode <= M_HOLD;
              lock <= flag;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: mode <= M_HOLD;
        endcase
      end
    end
  end

  assign prewarn_irq = irq;
  assign rst_req     = lock | (mode == M_HOLD);
  assign was_expired = flag;

  // R3: interrupt is a single-cycle pulse
  p_irq_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prewarn_irq |=> !prewarn_irq);

  // R3: interrupt only accompanies a set flag in the prewarning phase
  p_irq_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prewarn_irq |-> (was_expired && mode == M_WARN));

  // R4: service cannot restart the prewarning window
  p_warn_ignores_service_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_WARN && service && !ovf) |=> (cnt == $past(cnt) + 1'b1));

  // R5: a reset request holds until a reset
  p_req_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

  // R7: flag falls only through a prewarning clear
  p_flag_clear_only_warn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (was_expired && !(mode == M_WARN && clr_flag)) |=> was_expired);

  // R8: expiry with flag set in normal phase locks without interrupt
  p_no_irq_when_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RUN && ovf && !service && was_expired && !lock) |=> (rst_req && !prewarn_irq));

  // R9: the lock is released only by a power reset
  p_lock_survives_r9: assert property (@(posedge clk) disable iff (!rst_n && rst_is_power)
    lock |=> lock);

endmodule

// File: tb/tb_wdog_prewarn.sv
module tb_wdog_prewarn;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 8;
  localparam int PWC = 32;
  localparam int SPAN = 1 << W;
  localparam int EV_IRQ = 0;
  localparam int EV_RST = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0, rst_is_power = 1'b1, service = 1'b0, clr_flag = 1'b0;
  logic [W-1:0] reload_val = 8'd200;
  logic prewarn_irq, rst_req, was_expired;

  wdog_prewarn #(.CNT_W(W), .PREWARN_CYCLES(PWC)) dut (
    .clk(clk), .rst_n(rst_n), .rst_is_power(rst_is_power), .service(service),
    .clr_flag(clr_flag), .reload_val(reload_val), .prewarn_irq(prewarn_irq),
    .rst_req(rst_req), .was_expired(was_expired));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int kind; int at; string tag; } exp_t;
  exp_t q[$];
  int n_tests = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic expect_ev(input int kind, input int at, input string tag);
    exp_t e;
    e.kind = kind; e.at = at; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic got(input int kind);
    exp_t e;
    if (q.size() == 0) begin
      check(1'b0, "R9", (kind == EV_IRQ) ? "unexpected irq at cycle" : "unexpected rst_req at cycle", cyc, -1);
    end else begin
      e = q.pop_front();
      check(e.kind == kind, e.tag, "event kind", kind, e.kind);
      check(e.at == cyc, e.tag, "event cycle", cyc, e.at);
    end
  endtask

  logic prev_req = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prewarn_irq === 1'b1) got(EV_IRQ);
      if (rst_req === 1'b1 && prev_req !== 1'b1) got(EV_RST);
    end
    prev_req <= rst_req;
  end

  int c0;
  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask
  task automatic do_reset(input bit pwr);
    @(negedge clk);
    rst_n = 1'b0; rst_is_power = pwr;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; rst_is_power = 1'b0;
    c0 = cyc;
  endtask
  task automatic pulse_service(output int load_at);
    service = 1'b1; @(negedge clk); service = 1'b0; load_at = cyc;
  endtask
  task automatic pulse_clr();
    clr_flag = 1'b1; @(negedge clk); clr_flag = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d, expected end before 20000", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int t, ld;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; rst_is_power = 1'b0; c0 = cyc;
    check(rst_req == 0, "R1", "rst_req after power reset", rst_req, 0);
    check(prewarn_irq == 0, "R1", "irq after power reset", prewarn_irq, 0);
    check(was_expired == 0, "R1", "flag after power reset", was_expired, 0);

    // R2: service reload, then expiry timing; R3: prewarning entry
    wait_cyc(c0 + 20);
    pulse_service(ld);
    t = ld + SPAN - 200;
    expect_ev(EV_IRQ, t, "R2");
    wait_cyc(t);
    check(was_expired == 1, "R3", "flag on prewarning entry", was_expired, 1);
    // R4: service ignored in prewarning
    wait_cyc(t + 3); pulse_service(ld);
    // R7: clear allowed in prewarning
    wait_cyc(t + 10); pulse_clr();
    wait_cyc(t + 12);
    check(was_expired == 0, "R7", "flag after clear in prewarning", was_expired, 0);
    expect_ev(EV_RST, t + PWC, "R4");
    wait_cyc(t + PWC + 8);
    check(rst_req == 1, "R5", "held request", rst_req, 1);
    check(q.size() == 0, "R5", "pending events", q.size(), 0);
    do_reset(1'b0);
    check(rst_req == 0, "R5", "request after user reset", rst_req, 0);

    // R6: expiry of window with flag still set locks
    reload_val = 8'd100;
    do_reset(1'b0);
    t = c0 + SPAN - 100;
    expect_ev(EV_IRQ, t, "R3");
    expect_ev(EV_RST, t + PWC, "R6");
    wait_cyc(t + PWC + 2);
    check(rst_req == 1, "R6", "locked request", rst_req, 1);
    pulse_clr();
    @(negedge clk);
    check(was_expired == 1, "R7", "flag after clear while requesting", was_expired, 1);
    do_reset(1'b0);
    check(rst_req == 1, "R9", "lock through user reset", rst_req, 1);
    check(was_expired == 1, "R8", "flag through user reset", was_expired, 1);
    wait_cyc(c0 + SPAN + 20);
    check(q.size() == 0, "R9", "pending events while locked", q.size(), 0);
    do_reset(1'b1);
    check(rst_req == 0, "R9", "request after power reset", rst_req, 0);
    check(was_expired == 0, "R1", "flag after power reset", was_expired, 0);

    // R8: user reset during prewarning, next expiry locks with no irq
    reload_val = 8'd150;
    do_reset(1'b1);
    t = c0 + SPAN - 150;
    expect_ev(EV_IRQ, t, "R3");
    wait_cyc(t + 5);
    do_reset(1'b0);
    check(was_expired == 1, "R8", "flag kept by user reset", was_expired, 1);
    check(rst_req == 0, "R8", "request after user reset", rst_req, 0);
    wait_cyc(c0 + 10); pulse_clr();
    @(negedge clk);
    check(was_expired == 1, "R7", "flag after clear in normal phase", was_expired, 1);
    expect_ev(EV_RST, c0 + SPAN - 150, "R8");
    wait_cyc(c0 + SPAN - 150 + 20);
    check(rst_req == 1, "R8", "lock on expiry with flag", rst_req, 1);
    do_reset(1'b0);
    check(rst_req == 1, "R9", "lock kept by user reset", rst_req, 1);
    repeat (10) @(negedge clk);
    check(q.size() == 0, "R8", "pending events at end", q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule